// File: doc/BRIEF.md
# SD SPI Block Write Engine

This engine carries out the data phase of a memory-card write in SPI mode. The write command has already been issued and accepted. After a `start` pulse, the engine sends each block as a byte stream: a filler byte, a start token, the payload fetched from a byte read port, and a 16-bit CRC trailer. It then reads bytes from the card until it finds the data-response token, and polls again until the card stops signalling busy.

For a multi-block write, the engine closes the transfer with a stop token and a final busy wait. One `done` pulse reports the outcome on `status`. The engine drives every byte through a request/acknowledge handshake to an external SPI byte shifter. Each acknowledged transfer is full duplex: the byte sent goes out on the wire and the byte clocked back returns on `xfer_rx`. A "read" is a transfer of 0xFF.

Top module: `sd_blkwr`

## Requirements
- R1: Each block begins with the byte 0xFF and then a start token: 0xFE when `multi` was low at `start`, 0xFC when it was high.
- R2: Payload bytes come from the read port in address order. The address starts at 0 and runs on across blocks, so byte j of block k comes from address k*`block_size`+j. `rd_data` is taken one cycle after `rd_addr` is presented.
- R3: The two bytes after the payload are a CRC-16 of that block's payload, most significant byte first. The CRC uses polynomial 0x1021 with a zero initial value. When `crc_en` was low at `start`, both bytes are 0x00.
- R4: After the CRC, the engine reads at most RESP_TRIES bytes. The response token is the first byte read with bit 4 equal to 0 and bit 0 equal to 1.
- R5: A token whose bits 4:0 equal 5'b00101 is accepted. Any other token, or no token within RESP_TRIES reads, ends the transfer at once with status 2'b01, and no further byte is sent.
- R6: After acceptance, the engine reads until a byte equals 0xFF, ignoring the value of the first read. If BUSY_LIMIT reads pass without such a byte, the transfer ends with status 2'b10.
- R7: After the last block of a successful multi-block write, the engine sends 0xFF then 0xFD, then performs the R6 busy wait. A single-block write sends neither byte.
- R8: Each accepted `start` yields exactly one single-cycle `done` pulse. `status` is valid from that pulse until the next `start`, and 2'b00 means success.
- R9: While `xfer_req` is high and `xfer_ack` is low, `xfer_req` stays high and `xfer_byte` holds its value. No transfer is requested while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a write; accepted only when idle |
| multi | input | 1 | Multi-block mode select |
| crc_en | input | 1 | Generate the CRC trailer (else send zeros) |
| block_count | input | CNT_W | Number of blocks, at least 1 |
| block_size | input | SZ_W | Payload bytes per block, at least 1 |
| rd_addr | output | ADDR_W | Payload read address |
| rd_data | input | 8 | Payload byte, valid one cycle after `rd_addr` |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_byte | output | 8 | Byte to send |
| xfer_ack | input | 1 | Transfer completed this cycle |
| xfer_rx | input | 8 | Byte received in the completed transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 00 ok, 01 rejected or no token, 10 busy timeout |

## Verification
The checks assume the shifter raises `xfer_ack` only while `xfer_req` is high, with `xfer_rx` valid in that same cycle. They also assume `start` is pulsed only while the engine is idle, with nonzero `block_count` and `block_size`. The bench's card model acknowledges only pending requests, after a random delay of zero or more cycles. Each new `start` waits for the previous `done`, and every drawn size and count is at least 1. Random response codes are built with bit 0 set and bit 4 clear, and the accepted code is excluded from them, so each draw is a real rejection.

// File: rtl/sd_blkwr.sv
module sd_blkwr #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int SZ_W       = 10,
  parameter int RESP_TRIES = 8,
  parameter int BUSY_LIMIT = 3000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              multi,
  input  logic              crc_en,
  input  logic [CNT_W-1:0]  block_count,
  input  logic [SZ_W-1:0]   block_size,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              xfer_req,
  output logic [7:0]        xfer_byte,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              done,
  output logic [1:0]        status
);
  localparam int POLL_W = $clog2(BUSY_LIMIT + 1);
  localparam int TRY_W  = $clog2(RESP_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_TOK, S_FETCH, S_LOAD, S_DATA, S_CRCH, S_CRCL,
    S_RESP, S_BUSY, S_SFILL, S_STOP, S_SBUSY, S_FIN
  } st_t;

  st_t               st;
  logic              mul_q, crc_on;
  logic [CNT_W-1:0]  nblk, blk;
  logic [SZ_W-1:0]   bsz, idx;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        dbuf;
  logic [15:0]       crc;
  logic [TRY_W-1:0]  tries;
  logic [POLL_W-1:0] poll;
  logic [1:0]        stat;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  wire fire     = xfer_req & xfer_ack;
  wire tok_hit  = (xfer_rx & 8'h11) == 8'h01;
  wire busy_end = (poll != '0) && (xfer_rx == 8'hFF);
  wire poll_out = poll == POLL_W'(BUSY_LIMIT - 1);

  assign xfer_req = !(st inside {S_IDLE, S_FETCH, S_LOAD, S_FIN});
  assign rd_addr  = ptr;
  assign done     = st == S_FIN;
  assign status   = stat;

  always_comb begin
    case (st)
      S_TOK:   xfer_byte = mul_q ? 8'hFC : 8'hFE;
      S_DATA:  xfer_byte = dbuf;
      S_CRCH:  xfer_byte = crc_on ? crc[15:8] : 8'h00;
      S_CRCL:  xfer_byte = crc_on ? crc[7:0] : 8'h00;
      S_STOP:  xfer_byte = 8'hFD;
      default: xfer_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mul_q <= 1'b0; crc_on <= 1'b0;
      nblk <= '0; blk <= '0; bsz <= '0; idx <= '0; ptr <= '0;
      dbuf <= '0; crc <= '0; tries <= '0; poll <= '0; stat <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mul_q <= multi; crc_on <= crc_en; nblk <= block_count; bsz <= block_size;
          blk <= '0; ptr <= '0; stat <= 2'b00; st <= S_FILL;
        end
        S_FILL: if (fire) st <= S_TOK;
        S_TOK: if (fire) begin
          idx <= '0; crc <= '0; st <= S_FETCH;
        end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          dbuf <= rd_data; st <= S_DATA;
        end
        S_DATA: if (fire) begin
          crc <= crc_step(crc, dbuf);
          ptr <= ptr + 1'b1;
          if (idx == bsz - 1'b1) st <= S_CRCH;
          else begin
            idx <= idx + 1'b1; st <= S_FETCH;
          end
        end
        S_CRCH: if (fire) st <= S_CRCL;
        S_CRCL: if (fire) begin
          tries <= '0; st <= S_RESP;
        end
        S_RESP: if (fire) begin
          if (tok_hit) begin
            if (xfer_rx[4:0] == 5'b00101) begin
              poll <= '0; st <= S_BUSY;
            end else begin
              stat <= 2'b01; st <= S_FIN;
            end
          end else if (tries == TRY_W'(RESP_TRIES - 1)) begin
            stat <= 2'b01; st <= S_FIN;
          end else tries <= tries + 1'b1;
        end
        S_BUSY, S_SBUSY: if (fire) begin
          if (busy_end) begin
            if (st == S_SBUSY) st <= S_FIN;
            else if (blk == nblk - 1'b1) st <= mul_q ? S_SFILL : S_FIN;
            else begin
              blk <= blk + 1'b1; st <= S_FILL;
            end
          end else if (poll_out) begin
            stat <= 2'b10; st <= S_FIN;
          end else poll <= poll + 1'b1;
        end
        S_SFILL: if (fire) st <= S_STOP;
        S_STOP: if (fire) begin
          poll <= '0; st <= S_SBUSY;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_blkwr_chk.sv
module sd_blkwr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              xfer_req,
  input logic [7:0]        xfer_byte,
  input logic              xfer_ack,
  input logic              done,
  input logic [1:0]        status
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_byte));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_req);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'b11);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (rd_addr == $past(rd_addr)) || (rd_addr == $past(rd_addr) + 1'b1));
endmodule

bind sd_blkwr sd_blkwr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
  .xfer_req(xfer_req), .xfer_byte(xfer_byte), .xfer_ack(xfer_ack),
  .done(done), .status(status)
);

// File: tb/sd_blkwr_bench.sv
module sd_blkwr_bench;
  localparam int ADDR_W = 10, CNT_W = 4, SZ_W = 7, TRIES = 8, LIMIT = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, multi = 1'b0, crc_en = 1'b0;
  logic [CNT_W-1:0] block_count = '0;
  logic [SZ_W-1:0] block_size = '0;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic xfer_req, xfer_ack = 1'b0, done;
  logic [7:0] xfer_byte, xfer_rx = 8'hFF;
  logic [1:0] status;

  sd_blkwr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SZ_W(SZ_W),
             .RESP_TRIES(TRIES), .BUSY_LIMIT(LIMIT)) u_sd_blkwr (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .crc_en(crc_en),
    .block_count(block_count), .block_size(block_size), .rd_addr(rd_addr),
    .rd_data(rd_data), .xfer_req(xfer_req), .xfer_byte(xfer_byte),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .done(done), .status(status));

  always #5 clk = ~clk;

  logic [7:0] mem [0:(1<<ADDR_W)-1];
  always @(posedge clk) rd_data <= mem[rd_addr];

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] logb [0:4095];
  logic [7:0] expb [0:4095];
  int log_n = 0, exp_n = 0, exp_stat = 0;
  int c_phase = 0, c_n = 0, c_size = 0, c_lat = 0, c_busy = 0;
  logic [7:0] c_tok = 8'hE5;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [7:0] card(input logic [7:0] b);
    logic [7:0] rx = 8'hFF;
    case (c_phase)
      0: begin
        if (b == 8'hFE || b == 8'hFC) begin c_phase = 1; c_n = 0; end
        else if (b == 8'hFD) begin c_phase = 3; c_n = 0; end
      end
      1: begin
        c_n++;
        if (c_n == c_size + 2) begin c_phase = 2; c_n = 0; end
      end
      2: begin
        if (c_n < c_lat) c_n++;
        else begin
          rx = c_tok;
          c_n = 0;
          c_phase = (c_tok[4:0] == 5'b00101) ? 3 : 0;
        end
      end
      default: begin
        if (c_n == 0) rx = 8'hFF;
        else if (c_n <= c_busy) rx = 8'h00;
        else begin rx = 8'hFF; c_phase = 0; end
        c_n++;
      end
    endcase
    return rx;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      xfer_ack = 1'b0;
      xfer_rx = 8'hFF;
      if (xfer_req && ($urandom % 3) != 0) begin
        if (log_n < 4096) logb[log_n] = xfer_byte;
        log_n++;
        xfer_rx = card(xfer_byte);
        xfer_ack = 1'b1;
      end
    end
  end

  task automatic push(input logic [7:0] b);
    expb[exp_n] = b;
    exp_n++;
  endtask

  task automatic busy_exp(input int busy, output bit timed_out);
    timed_out = (busy + 2 > LIMIT);
    for (int i = 0; i < (timed_out ? LIMIT : busy + 2); i++) push(8'hFF);
  endtask

  task automatic build(input int nb, input int sz, input bit mul, input bit crcon,
                       input int lat, input logic [7:0] tok, input int busy);
    bit to;
    exp_n = 0;
    for (int b = 0; b < nb; b++) begin
      logic [15:0] c = 16'h0000;
      push(8'hFF);
      push(mul ? 8'hFC : 8'hFE);
      for (int j = 0; j < sz; j++) begin
        push(mem[b*sz + j]);
        c = crc_bit(c, mem[b*sz + j]);
      end
      push(crcon ? c[15:8] : 8'h00);
      push(crcon ? c[7:0] : 8'h00);
      if (lat >= TRIES) begin
        for (int i = 0; i < TRIES; i++) push(8'hFF);
        exp_stat = 1; return;
      end
      for (int i = 0; i <= lat; i++) push(8'hFF);
      if (tok[4:0] != 5'b00101) begin exp_stat = 1; return; end
      busy_exp(busy, to);
      if (to) begin exp_stat = 2; return; end
    end
    if (mul) begin
      push(8'hFF);
      push(8'hFD);
      busy_exp(busy, to);
      if (to) begin exp_stat = 2; return; end
    end
    exp_stat = 0;
  endtask

  task automatic run(input int nb, input int sz, input bit mul, input bit crcon,
                     input int lat, input logic [7:0] tok, input int busy, input string tag);
    int pulses = 0, got = -1, bad_at = -1, n_after;
    c_phase = 0; c_n = 0; c_size = sz; c_lat = lat; c_tok = tok; c_busy = busy;
    build(nb, sz, mul, crcon, lat, tok, busy);
    @(negedge clk);
    log_n = 0;
    multi = mul; crc_en = crcon;
    block_count = CNT_W'(nb); block_size = SZ_W'(sz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20000 && pulses == 0; t++) begin
      if (done) begin pulses++; got = int'(status); end
      else @(negedge clk);
    end
    n_after = log_n;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check(got == exp_stat, {tag, " status"}, got, exp_stat);
    check(pulses == 1, "R8 done pulses", pulses, 1);
    check(log_n == exp_n && n_after == log_n, {tag, " byte count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad_at < 0 && logb[i] !== expb[i]) bad_at = i;
    if (bad_at >= 0) check(1'b0, {tag, " stream byte"}, int'(logb[bad_at]), int'(expb[bad_at]));
    else check(1'b1, tag, 0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog: actual no completion expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(xfer_req == 1'b0, "R9 idle request after reset", int'(xfer_req), 0);
    check(done == 1'b0 && status == 2'b00, "R8 reset outputs", int'({done, status}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(xfer_req == 1'b0, "R9 idle request", int'(xfer_req), 0);

    run(1, 16, 1'b0, 1'b1, 2, 8'hE5, 4, "R1 R2 R3 R6 single accepted");
    run(1, 12, 1'b0, 1'b1, 1, 8'h0B, 3, "R5 rejected token");
    run(3, 8, 1'b1, 1'b1, 0, 8'h05, 5, "R7 R2 multi with stop");
    run(1, 5, 1'b0, 1'b1, TRIES, 8'hE5, 0, "R4 no token");
    run(2, 4, 1'b1, 1'b1, 3, 8'hE5, 60, "R6 busy timeout");
    run(2, 6, 1'b0, 1'b0, 0, 8'hE5, 2, "R3 crc disabled");
    run(1, 1, 1'b1, 1'b1, 7, 8'h25, 0, "R4 R6 last try first poll ignored");
    run(1, 9, 1'b0, 1'b1, 0, 8'hE5, LIMIT - 2, "R6 busy at limit");

    for (int k = 0; k < 8; k++) begin
      int nb = $urandom_range(1, 3), sz = $urandom_range(1, 20);
      int lat = $urandom_range(0, 7), busy = $urandom_range(0, 10);
      logic [7:0] tok = 8'hE5;
      if ($urandom_range(0, 3) == 0) begin
        tok = (8'($urandom) & 8'hEE) | 8'h01;
        if (tok[4:0] == 5'b00101) tok = tok ^ 8'h02;
      end
      run(nb, sz, 1'($urandom), 1'($urandom), lat, tok, busy, "R1 R5 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule